// File: doc/BRIEF.md
# LCD Multiplex Scan Sequencer

This block scans the rows of a multiplexed LCD at 2, 4 or 8 ways, in step with an externally supplied frame signal. Each rising edge of the frame input moves the scan to the next row. The block reads that row's 40-bit word from the display memory and turns it into a 2-bit drive-level code for each of its 40 outputs. A downstream bias switch turns each code into a voltage. The frame input's level sets the AC polarity of every code. The block therefore never applies a net DC component, provided the frame signal has a 50 % duty.

In row/column mode the lowest `MUX` outputs are backplane drivers and the rest are segment columns. In column-only mode all 40 outputs are columns and the scan runs over all 8 memory rows. This lets several devices share one set of backplanes. A strobe input returns the scan to the first row so that cascaded devices stay aligned. A blank input turns off every pixel while the memory is still being filled.

Top module: `lcd_scan_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, every code in `drv_code` becomes 00. The scan index returns to row 1 (index 0), and the latched row word is cleared.
- R2: In row/column mode, each rising edge of `fr_in` advances the scan index by one. After index `MUX`-1 the index wraps to 0. A falling edge of `fr_in` does not move the scan.
- R3: In column-only mode (`col_only`=1), the scan index runs from 0 to 7 before it wraps to 0.
- R4: A clock edge with `strobe` high sets the scan index to 0 and loads memory row 0, whatever `fr_in` does.
- R5: The row word is captured only at a scan event, which is an `fr_in` rising edge or a strobe. A memory change between events stays invisible at the outputs until the next event.
- R6: The code values are 00 for VSS, 01 for the low intermediate level, 10 for the high intermediate level and 11 for VLCD. In row/column mode, output j for j < `MUX` is a backplane. When j equals the scan index, it gets 11 if the frame level is 1 and 00 if it is 0. Otherwise it gets 01 if the frame level is 1 and 10 if it is 0.
- R7: Column output i (i ≥ `MUX` in row/column mode) takes bit i of the latched word. A set bit gives 00 when the frame level is 1 and 11 when it is 0. A clear bit gives 10 when the frame level is 1 and 01 when it is 0.
- R8: In column-only mode, all 40 outputs, including 0 to `MUX`-1, follow the column rule of R7.
- R9: While `blank` is high, every column output takes the clear-bit code of R7. Backplane outputs are not affected.
- R10: A change of `fr_in` shows up in `drv_code` after two clock edges. A change of `blank` or `col_only` shows up after one edge.
- R11: `ram_rd_addr` is combinational. It gives the row that the next scan event would load: 0 while `strobe` is high, otherwise the successor of the current index, with the wrap of R2 or R3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| fr_in | input | 1 | Frame signal (synchronous to clk); level sets polarity, rising edge advances the scan |
| strobe | input | 1 | Return scan to row 1 |
| blank | input | 1 | Force all pixels off |
| col_only | input | 1 | 1: all outputs are columns, 8-row scan |
| ram_rd_addr | output | 3 | Display memory row to read |
| ram_rd_data | input | 40 | Word read from memory, combinational |
| drv_code | output | 80 | 2-bit level code per output, output i at bits [2i+1:2i] |

## Verification
The frame input passes through one register before the drive register, so a frame edge shows in the codes two edges after it is applied. The blank and mode inputs feed the drive register directly and show after one edge. The read address is combinational and is compared one nanosecond after the inputs settle. The bench applies inputs at the falling clock edge and updates its reference model at the rising edge. It updates the model from the state held before that edge and then compares at the next falling edge. Each expected code therefore lines up with the exact register stage that produces it.

// File: rtl/lcd_scan_pkg.sv
// Shared level codes and code-selection helpers for the LCD scan sequencer.
// Assumes a 2-bit code per output, decoded by an external bias switch.
package lcd_scan_pkg;

    typedef enum logic [1:0] {
        LVL_VSS  = 2'b00,
        LVL_LOW  = 2'b01,
        LVL_HIGH = 2'b10,
        LVL_VLCD = 2'b11
    } lvl_t;

    // Backplane code: the selected row goes to the extreme that opposes the columns
    function automatic lvl_t backplane_lvl(input logic selected, input logic frame);
        if (selected) return frame ? LVL_VLCD : LVL_VSS;
        return frame ? LVL_LOW : LVL_HIGH;
    endfunction

    // Segment code: a lit pixel takes the extreme, an unlit one the far intermediate
    function automatic lvl_t segment_lvl(input logic lit, input logic frame);
        if (lit) return frame ? LVL_VSS : LVL_VLCD;
        return frame ? LVL_HIGH : LVL_LOW;
    endfunction

endpackage

// File: rtl/lcd_row_ctr.sv
// Row scan counter and row-word latch.
// Registers the frame input, detects its rising edge, and advances the row
// index on each rising edge or forces it to zero on strobe. The word read
// from memory is captured at the same event. Assumes a combinational read.
module lcd_row_ctr #(
    parameter int ROWS = 8,
    parameter int MUX  = 4,
    parameter int W    = 40,
    parameter int AW   = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fr_in,
    input  logic          strobe,
    input  logic          col_only,
    input  logic [W-1:0]  ram_data,
    output logic [AW-1:0] rd_addr,
    output logic [AW-1:0] row_idx,
    output logic [W-1:0]  word_q,
    output logic          fr_q
);
    localparam logic [AW-1:0] LAST_COL = AW'(ROWS - 1);
    localparam logic [AW-1:0] LAST_MUX = AW'(MUX - 1);

    logic [AW-1:0] last_row;
    logic [AW-1:0] row_nxt;
    logic          fr_rise;
    logic          scan_ev;

    // Pick the wrap point and the successor row
    always_comb begin
        last_row = col_only ? LAST_COL : LAST_MUX;
        fr_rise  = fr_in & ~fr_q;
        scan_ev  = fr_rise | strobe;
        if (strobe)                row_nxt = '0;
        else if (row_idx >= last_row) row_nxt = '0;
        else                       row_nxt = row_idx + AW'(1);
    end

    assign rd_addr = row_nxt;

    // Frame register, row index and latched word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fr_q    <= 1'b0;
            row_idx <= '0;
            word_q  <= '0;
        end else begin
            fr_q <= fr_in;
            if (scan_ev) begin
                row_idx <= row_nxt;
                word_q  <= ram_data;
            end
        end
    end

    // R4
    strobe_home_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> (row_idx == '0));

    // R5
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe && !(fr_in && !fr_q)) |=> ($stable(row_idx) && $stable(word_q)));

    // R2
    row_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!col_only && (fr_in && !fr_q)) |=> (row_idx < AW'(MUX)));

endmodule

// File: rtl/lcd_drv_map.sv
// Per-output level-code generator with a registered output.
// Outputs below MUX act as backplanes in row/column mode and as columns
// in column-only mode. All others are always columns. Blank masks the data.
module lcd_drv_map
    import lcd_scan_pkg::*;
#(
    parameter int NOUT = 40,
    parameter int MUX  = 4,
    parameter int AW   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     row_idx,
    input  logic [NOUT-1:0]   word_q,
    input  logic              fr_q,
    input  logic              blank,
    input  logic              col_only,
    output logic [2*NOUT-1:0] drv_code
);
    localparam int NCOL = NOUT - MUX;

    logic [MUX-1:0]  row_ext;
    logic [NCOL-1:0] col_ext;
    logic [NCOL-1:0] col_lsb;
    logic            started;

    for (genvar i = 0; i < NOUT; i++) begin : g_out
        lvl_t code_nxt;
        if (i < MUX) begin : g_dual
            // Backplane or column, chosen by mode
            always_comb begin
                if (!col_only) code_nxt = backplane_lvl(row_idx == AW'(i), fr_q);
                else           code_nxt = segment_lvl(word_q[i] & ~blank, fr_q);
            end
            assign row_ext[i] = (drv_code[2*i+1] == drv_code[2*i]);
        end else begin : g_col
            // Column only
            always_comb code_nxt = segment_lvl(word_q[i] & ~blank, fr_q);
            assign col_ext[i-MUX] = (drv_code[2*i+1] == drv_code[2*i]);
            assign col_lsb[i-MUX] = drv_code[2*i];
        end
        // Register the code for this output
        always_ff @(posedge clk) begin
            if (!rst_n) drv_code[2*i+1:2*i] <= LVL_VSS;
            else        drv_code[2*i+1:2*i] <= code_nxt;
        end
    end

    // Marks that the drive register holds a computed value
    always_ff @(posedge clk) begin
        if (!rst_n) started <= 1'b0;
        else        started <= 1'b1;
    end

    // R6
    one_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (started && !$past(col_only)) |-> $onehot0(row_ext));

    // R9
    blank_cols_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (started && $past(blank)) |-> (col_ext == '0));

    // R7
    col_polarity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        started |-> (col_lsb == ($past(fr_q) ? '0 : '1)));

endmodule

// File: rtl/lcd_scan_seq.sv
// Top of the LCD multiplex scan sequencer.
// Ties the row counter to the per-output code map. Assumes fr_in is
// synchronous to clk and that the display memory answers in the same cycle.
module lcd_scan_seq #(
    parameter int NOUT = 40,
    parameter int ROWS = 8,
    parameter int MUX  = 4,
    localparam int AW  = $clog2(ROWS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fr_in,
    input  logic              strobe,
    input  logic              blank,
    input  logic              col_only,
    output logic [AW-1:0]     ram_rd_addr,
    input  logic [NOUT-1:0]   ram_rd_data,
    output logic [2*NOUT-1:0] drv_code
);
    logic [AW-1:0]   row_idx;
    logic [NOUT-1:0] word_q;
    logic            fr_q;

    lcd_row_ctr #(.ROWS(ROWS), .MUX(MUX), .W(NOUT), .AW(AW)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .fr_in    (fr_in),
        .strobe   (strobe),
        .col_only (col_only),
        .ram_data (ram_rd_data),
        .rd_addr  (ram_rd_addr),
        .row_idx  (row_idx),
        .word_q   (word_q),
        .fr_q     (fr_q)
    );

    lcd_drv_map #(.NOUT(NOUT), .MUX(MUX), .AW(AW)) u_map (
        .clk      (clk),
        .rst_n    (rst_n),
        .row_idx  (row_idx),
        .word_q   (word_q),
        .fr_q     (fr_q),
        .blank    (blank),
        .col_only (col_only),
        .drv_code (drv_code)
    );

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (drv_code == '0));

endmodule

// File: tb/lcd_scan_seq_test.sv
module lcd_scan_seq_test;
    localparam int NOUT = 40;
    localparam int ROWS = 8;
    localparam int MUX  = 4;

    logic clk = 1'b0;
    logic rst_n, fr_in, strobe, blank, col_only;
    logic [2:0]  ram_rd_addr;
    logic [NOUT-1:0] ram_rd_data;
    logic [2*NOUT-1:0] drv_code;
    logic [NOUT-1:0] mem [ROWS];

    int n_chk = 0;
    int n_bad = 0;
    int m_row;
    logic [NOUT-1:0] m_word;
    bit m_fr;

    always #2.5 clk = ~clk;
    assign ram_rd_data = mem[ram_rd_addr];

    lcd_scan_seq #(.NOUT(NOUT), .ROWS(ROWS), .MUX(MUX)) uut (
        .clk(clk), .rst_n(rst_n), .fr_in(fr_in), .strobe(strobe), .blank(blank),
        .col_only(col_only), .ram_rd_addr(ram_rd_addr), .ram_rd_data(ram_rd_data),
        .drv_code(drv_code)
    );

    // Expected codes from R6..R9
    function automatic logic [2*NOUT-1:0] expect_codes(int row, logic [NOUT-1:0] w,
                                                       bit f, bit b, bit c);
        logic [2*NOUT-1:0] r;
        logic [1:0] cd;
        for (int i = 0; i < NOUT; i++) begin
            if (!c && i < MUX) cd = (i == row) ? (f ? 2'b11 : 2'b00) : (f ? 2'b01 : 2'b10);
            else if (w[i] && !b) cd = f ? 2'b00 : 2'b11;
            else cd = f ? 2'b10 : 2'b01;
            r[2*i +: 2] = cd;
        end
        return r;
    endfunction

    function automatic int next_row(bit s, bit c);
        int last = c ? ROWS - 1 : MUX - 1;
        if (s) return 0;
        return (m_row >= last) ? 0 : m_row + 1;
    endfunction

    task automatic check_codes(string tag, logic [2*NOUT-1:0] exp);
        n_chk++;
        if (drv_code !== exp) begin
            n_bad++;
            $display("FAIL %s drv_code actual=%h expected=%h", tag, drv_code, exp);
        end
    endtask

    // One clock: drive at falling edge, model at rising edge, compare at next falling edge
    task automatic step(bit f, bit s, bit b, bit c, string tag);
        int nxt;
        logic [2*NOUT-1:0] exp;
        fr_in = f; strobe = s; blank = b; col_only = c;
        #1;
        nxt = next_row(s, c);
        n_chk++;
        if (int'(ram_rd_addr) != nxt) begin
            n_bad++;
            $display("FAIL R11 ram_rd_addr actual=%0d expected=%0d", ram_rd_addr, nxt);
        end
        @(posedge clk);
        exp = expect_codes(m_row, m_word, m_fr, b, c);
        if ((f && !m_fr) || s) begin
            m_word = mem[nxt];
            m_row  = nxt;
        end
        m_fr = f;
        @(negedge clk);
        check_codes(tag, exp);
    endtask

    initial begin : watchdog
        #(5ns * 200000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        bit f, b, c;
        void'($urandom(32'h5EED_1CD0));
        for (int r = 0; r < ROWS; r++) mem[r] = {$urandom, $urandom};
        rst_n = 0; fr_in = 0; strobe = 0; blank = 0; col_only = 0;
        m_row = 0; m_word = '0; m_fr = 0;
        repeat (3) @(negedge clk);
        check_codes("R1", '0);
        rst_n = 1;

        // R2: row scan with wrap, falling edges inert
        for (int k = 0; k < 2 * (MUX + 2); k++) step(k[0] == 0, 0, 0, 0, "R2");
        // R10: two edges from frame change to codes
        step(1, 0, 0, 0, "R10"); step(1, 0, 0, 0, "R10");
        step(0, 0, 0, 0, "R10"); step(0, 0, 0, 0, "R10");
        // R6: all-dark memory, backplanes only
        for (int r = 0; r < ROWS; r++) mem[r] = '0;
        for (int k = 0; k < 12; k++) step(k[0] == 0, 0, 0, 0, "R6");
        // R3 / R8: column-only, eight-row scan
        for (int r = 0; r < ROWS; r++) mem[r] = {$urandom, $urandom};
        for (int k = 0; k < 20; k++) step(k[0] == 0, 0, 0, 1, "R3");
        for (int k = 0; k < 4; k++) step(k[0] == 0, 0, 0, 1, "R8");
        // R4: strobe, including with a rising frame edge
        step(1, 1, 0, 0, "R4"); step(0, 1, 0, 0, "R4"); step(0, 0, 0, 0, "R4");
        step(1, 0, 0, 0, "R4"); step(1, 1, 0, 0, "R4"); step(1, 0, 0, 0, "R4");
        // R5: memory change without a scan event stays hidden
        step(0, 0, 0, 0, "R5");
        mem[m_row] = ~mem[m_row];
        for (int r = 0; r < ROWS; r++) if (r != m_row) mem[r] = ~mem[r];
        for (int k = 0; k < 4; k++) step(0, 0, 0, 0, "R5");
        step(1, 0, 0, 0, "R5"); step(1, 0, 0, 0, "R5");
        // R9: blank over a bright memory
        for (int r = 0; r < ROWS; r++) mem[r] = '1;
        for (int k = 0; k < 10; k++) step(k[0] == 0, 0, 1, k > 5, "R9");
        step(0, 0, 0, 0, "R9"); step(0, 0, 0, 0, "R9");

        // R7: constrained random mix
        f = 0; b = 0; c = 0;
        for (int k = 0; k < 2000; k++) begin
            if ($urandom_range(14) == 0) mem[$urandom_range(ROWS - 1)] = {$urandom, $urandom};
            if ($urandom_range(2) == 0) f = ~f;
            if ($urandom_range(9) == 0) b = ~b;
            if ($urandom_range(199) == 0) c = ~c;
            step(f, $urandom_range(19) == 0, b, c, "R7");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule